// File: doc/BRIEF.md
# Three-Wire Radio Configuration Controller

This block is a host-side master that programs a 2.4 GHz radio over a three-wire link. The link has a chip-select, a serial clock and a data line that the block can release. After reset it holds every radio pin low for a power-up interval. From then on it accepts two commands. A full-load command assembles a 15-byte (120-bit) configuration word from its register inputs and shifts it out. A direction command sends only the single receive/transmit bit, which switches the radio's direction without reloading the rest of the configuration.

Before it shifts a full load, the block checks that the radio's packet length limit can be met. If either payload width, plus the address width, plus the CRC length, comes to more than 256 bits, the block raises an error flag and leaves the pins idle. It also refuses an address wider than 40 bits. All pin timing is counted in system clock cycles through three parameters: the power-up hold, the setup time from chip-select to the first clock, and the length of each clock half-phase.

Top module: `tw_cfg_ctrl`

## Requirements
- R1: From reset until the PWRUP_CYC-th clock edge after reset is released, `ce_o`, `cs_o`, `sclk_o` and `data_o` are 0, `data_oe_o` and `busy_o` are 1, and both start commands are ignored.
- R2: A full load sends 120 bits, most significant bit of each byte first, with the bytes in this order: channel-2 payload width, channel-1 payload width, channel-2 address bytes 4 down to 0, channel-1 address bytes 4 down to 0, the address/CRC byte, the mode byte, and the channel/direction byte.
- R3: The address/CRC byte is {address width in bits[7:2], 16-bit CRC select[1], CRC enable[0]}. The mode byte is {two-channel receive[7], burst mode[6], 1 Mbps[5], crystal code[4:2], power code[1:0]}. The last byte is {RF channel[7:1], receive=1/transmit=0[0]}.
- R4: After an accepted command, `cs_o` is high with `sclk_o` low for SETUP_CYC cycles. Each bit is then held for HALF_CYC cycles with `sclk_o` low, followed by HALF_CYC cycles with `sclk_o` high. Data changes only when the clock falls.
- R5: A direction command sends one bit, the value of `dir_rx_i`, with exactly one clock pulse, and keeps `ce_o` low while `cs_o` is high.
- R6: At the end of any command, `cs_o` and `sclk_o` are low and `data_oe_o` is 0. After a full load `ce_o` is 0. After a direction command `ce_o` equals the bit that was sent.
- R7: A full-load command whose check fails sets `cfg_err_o` on the next cycle and leaves the pins idle. The check fails if a payload width plus the address width plus the CRC bits (0, 8 or 16) exceeds 256, or if the address width exceeds 40. A total of exactly 256 is accepted, and an accepted full load clears `cfg_err_o`.
- R8: `busy_o` is high from the cycle after an accepted command until the cycle in which `cs_o` falls. Commands that arrive while busy are ignored.
- R9: If both commands arrive in the same idle cycle, the full load is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_full_i | input | 1 | Pulse: send the full configuration word |
| start_dir_i | input | 1 | Pulse: send only the direction bit |
| dir_rx_i | input | 1 | Direction bit for a direction command (1 = receive) |
| pay2_w_i | input | 8 | Channel-2 payload width in bits |
| pay1_w_i | input | 8 | Channel-1 payload width in bits |
| addr2_i | input | 40 | Channel-2 receive address |
| addr1_i | input | 40 | Channel-1 receive address |
| addr_w_i | input | 6 | Address width in bits |
| crc16_i | input | 1 | 1 selects a 16-bit CRC, 0 an 8-bit CRC |
| crc_en_i | input | 1 | CRC enable |
| dual_rx_i | input | 1 | Two-channel receive enable |
| burst_i | input | 1 | 1 selects burst mode, 0 direct mode |
| rate_1m_i | input | 1 | 1 selects 1 Mbps, 0 selects 250 kbps |
| xtal_i | input | 3 | Crystal frequency code |
| power_i | input | 2 | Output power code (0 = lowest, 3 = full) |
| rf_chan_i | input | 7 | RF channel number |
| rx_en_i | input | 1 | Direction bit placed in the full word |
| ce_o | output | 1 | Radio activate line |
| cs_o | output | 1 | Configuration chip-select |
| sclk_o | output | 1 | Serial clock |
| data_o | output | 1 | Serial data value |
| data_oe_o | output | 1 | Data line drive enable (0 = released) |
| busy_o | output | 1 | Power-up or command in progress |
| cfg_err_o | output | 1 | Last full-load command failed the length check |

## Verification
The bench chases several corner cases, and each one shows up in a distinctive way when the design gets it wrong. Length totals of exactly 256 are tried with the CRC set to 16 bits and with it off. A design that compares with the wrong bound, or counts the CRC wrongly, either rejects these loads or accepts 257. An address width of 41 must also be refused. A byte-order or field-position slip changes the data pin in some bit cell and is caught on the cycle it happens. Commands that arrive during power-up or mid-shift would start a second frame or corrupt the current one. A direction command must leave the activate line at the bit that was sent, while a full load must leave it low. A design that grants a simultaneous direction command over the full load would send a single bit instead of 120.

// File: rtl/tw_cfg_pkg.sv
// Package tw_cfg_pkg
// Shared layout constants, the configuration field record and the controller
// state type for the three-wire configuration controller.
package tw_cfg_pkg;

    localparam int CFG_BYTES  = 15;
    localparam int CFG_BITS   = CFG_BYTES * 8;
    localparam int ADDR_BYTES = 5;
    localparam int ADDR_BITS  = ADDR_BYTES * 8;
    localparam int MAX_PKT    = 256;
    localparam int MAX_ADDR_W = 40;
    localparam int LEN_W      = 10;

    typedef struct packed {
        logic [7:0]           pay2_w;
        logic [7:0]           pay1_w;
        logic [ADDR_BITS-1:0] addr2;
        logic [ADDR_BITS-1:0] addr1;
        logic [5:0]           addr_w;
        logic                 crc16;
        logic                 crc_en;
        logic                 dual_rx;
        logic                 burst;
        logic                 rate_1m;
        logic [2:0]           xtal;
        logic [1:0]           power;
        logic [6:0]           chan;
        logic                 rx_en;
    } cfg_t;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH
    } st_e;

endpackage

// File: rtl/tw_cfg_word.sv
// Module tw_cfg_word
// Builds the 120-bit configuration word from the field record and checks
// the packet length budget. Purely combinational.
// Assumes: word bit CFG_BITS-1 is the first bit sent; byte k of the frame
// sits at word[CFG_BITS-1-8k -: 8].
module tw_cfg_word
    import tw_cfg_pkg::*;
(
    input  cfg_t                cfg_i,
    output logic [CFG_BITS-1:0] word_o,
    output logic                err_o
);

    logic [7:0] frame_b [CFG_BYTES];
    logic [LEN_W-1:0] crc_bits;
    logic [LEN_W-1:0] tot1;
    logic [LEN_W-1:0] tot2;

    // Fixed header bytes: payload widths first (R2)
    always_comb begin
        frame_b[0] = cfg_i.pay2_w;
        frame_b[1] = cfg_i.pay1_w;
    end

    // Address bytes, most significant byte first for each channel (R2)
    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_addr
        always_comb begin
            frame_b[2 + k]              = cfg_i.addr2[ADDR_BITS-1-8*k -: 8];
            frame_b[2 + ADDR_BYTES + k] = cfg_i.addr1[ADDR_BITS-1-8*k -: 8];
        end
    end

    // Trailing bit-field bytes (R3)
    always_comb begin
        frame_b[CFG_BYTES-3] = {cfg_i.addr_w, cfg_i.crc16, cfg_i.crc_en};
        frame_b[CFG_BYTES-2] = {cfg_i.dual_rx, cfg_i.burst, cfg_i.rate_1m,
                                cfg_i.xtal, cfg_i.power};
        frame_b[CFG_BYTES-1] = {cfg_i.chan, cfg_i.rx_en};
    end

    // Flatten the byte array into the shift word
    for (genvar b = 0; b < CFG_BYTES; b++) begin : g_flat
        assign word_o[CFG_BITS-1-8*b -: 8] = frame_b[b];
    end

    // Length budget check (R7)
    always_comb begin
        crc_bits = '0;
        if (cfg_i.crc_en) begin
            crc_bits = cfg_i.crc16 ? LEN_W'(16) : LEN_W'(8);
        end
        tot1  = LEN_W'(cfg_i.pay1_w) + LEN_W'(cfg_i.addr_w) + crc_bits;
        tot2  = LEN_W'(cfg_i.pay2_w) + LEN_W'(cfg_i.addr_w) + crc_bits;
        err_o = (tot1 > LEN_W'(MAX_PKT)) || (tot2 > LEN_W'(MAX_PKT)) ||
                (cfg_i.addr_w > 6'(MAX_ADDR_W));
    end

endmodule

// File: rtl/tw_cfg_timer.sv
// Module tw_cfg_timer
// Loadable down-counter that stops at zero; used for every timed phase.
// Assumes: loading N-1 gives a phase that lasts N cycles.
module tw_cfg_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt;

    // Count down toward zero, reload on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= W'(RST_VAL);
        end else if (load_i) begin
            cnt <= val_i;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero_o = (cnt == '0);

endmodule

// File: rtl/tw_cfg_shifter.sv
// Module tw_cfg_shifter
// Parallel-load, MSB-first shift register feeding the serial data pin.
// Assumes: a shift moves the next bit into the MSB position and fills zeros.
module tw_cfg_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         shift_i,
    output logic         msb_o
);

    logic [W-1:0] sh;

    // Load a new word or advance one bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load_i) begin
            sh <= val_i;
        end else if (shift_i) begin
            sh <= {sh[W-2:0], 1'b0};
        end
    end

    assign msb_o = sh[W-1];

endmodule

// File: rtl/tw_cfg_ctrl.sv
// Module tw_cfg_ctrl
// Host-side master for a radio's three-wire configuration port. It holds the
// pins low after reset, then sends either the full 120-bit configuration word
// or a single direction bit, and leaves the pins in their end state.
// Assumes: the start commands are single-cycle pulses synchronous to clk, and
// the configuration inputs are stable from the start pulse onward.
module tw_cfg_ctrl
    import tw_cfg_pkg::*;
#(
    parameter int PWRUP_CYC = 300000,
    parameter int SETUP_CYC = 1000,
    parameter int HALF_CYC  = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_full_i,
    input  logic        start_dir_i,
    input  logic        dir_rx_i,
    input  logic [7:0]  pay2_w_i,
    input  logic [7:0]  pay1_w_i,
    input  logic [39:0] addr2_i,
    input  logic [39:0] addr1_i,
    input  logic [5:0]  addr_w_i,
    input  logic        crc16_i,
    input  logic        crc_en_i,
    input  logic        dual_rx_i,
    input  logic        burst_i,
    input  logic        rate_1m_i,
    input  logic [2:0]  xtal_i,
    input  logic [1:0]  power_i,
    input  logic [6:0]  rf_chan_i,
    input  logic        rx_en_i,
    output logic        ce_o,
    output logic        cs_o,
    output logic        sclk_o,
    output logic        data_o,
    output logic        data_oe_o,
    output logic        busy_o,
    output logic        cfg_err_o
);

    localparam int TMR_MAX = (PWRUP_CYC > SETUP_CYC) ?
                             ((PWRUP_CYC > HALF_CYC) ? PWRUP_CYC : HALF_CYC) :
                             ((SETUP_CYC > HALF_CYC) ? SETUP_CYC : HALF_CYC);
    localparam int TW      = $clog2(TMR_MAX + 1);
    localparam int BW      = $clog2(CFG_BITS + 1);

    cfg_t                cfg;
    logic [CFG_BITS-1:0] word;
    logic                word_err;
    st_e                 st;
    logic [BW-1:0]       bits_left;
    logic                full_q;
    logic                dir_q;
    logic                ce_q;
    logic                err_q;
    logic                tmr_zero;
    logic                tmr_load;
    logic [TW-1:0]       tmr_val;
    logic                sh_load;
    logic [CFG_BITS-1:0] sh_val;
    logic                sh_shift;
    logic                sh_msb;
    logic                acc_full;
    logic                acc_dir;
    logic                last_bit;

    // Gather the register inputs into one record
    always_comb begin
        cfg.pay2_w  = pay2_w_i;
        cfg.pay1_w  = pay1_w_i;
        cfg.addr2   = addr2_i;
        cfg.addr1   = addr1_i;
        cfg.addr_w  = addr_w_i;
        cfg.crc16   = crc16_i;
        cfg.crc_en  = crc_en_i;
        cfg.dual_rx = dual_rx_i;
        cfg.burst   = burst_i;
        cfg.rate_1m = rate_1m_i;
        cfg.xtal    = xtal_i;
        cfg.power   = power_i;
        cfg.chan    = rf_chan_i;
        cfg.rx_en   = rx_en_i;
    end

    tw_cfg_word u_word (
        .cfg_i  (cfg),
        .word_o (word),
        .err_o  (word_err)
    );

    // Command acceptance: only when idle, full load wins (R8, R9, R7)
    always_comb begin
        acc_full = (st == ST_IDLE) && start_full_i && !word_err;
        acc_dir  = (st == ST_IDLE) && !start_full_i && start_dir_i;
        last_bit = (bits_left == BW'(1));
    end

    // Timer reload requests at each phase boundary (R4)
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = TW'(HALF_CYC - 1);
        case (st)
            ST_IDLE: begin
                if (acc_full || acc_dir) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETUP_CYC - 1);
                end
            end
            ST_SETUP, ST_LOW: tmr_load = tmr_zero;
            ST_HIGH:          tmr_load = tmr_zero && !last_bit;
            default:          tmr_load = 1'b0;
        endcase
    end

    tw_cfg_timer #(
        .W       (TW),
        .RST_VAL (PWRUP_CYC - 1)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    // Shift register load and advance (R2, R5)
    always_comb begin
        sh_load  = acc_full || acc_dir;
        sh_val   = acc_full ? word : {dir_rx_i, {(CFG_BITS-1){1'b0}}};
        sh_shift = (st == ST_HIGH) && tmr_zero && !last_bit;
    end

    tw_cfg_shifter #(
        .W (CFG_BITS)
    ) u_sh (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .val_i   (sh_val),
        .shift_i (sh_shift),
        .msb_o   (sh_msb)
    );

    // Phase sequencer and end-state registers (R1, R4, R6, R7)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_PWRUP;
            bits_left <= '0;
            full_q    <= 1'b0;
            dir_q     <= 1'b0;
            ce_q      <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            case (st)
                ST_PWRUP: begin
                    if (tmr_zero) st <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (start_full_i) begin
                        err_q <= word_err;
                    end
                    if (acc_full) begin
                        st        <= ST_SETUP;
                        bits_left <= BW'(CFG_BITS);
                        full_q    <= 1'b1;
                        ce_q      <= 1'b0;
                    end else if (acc_dir) begin
                        st        <= ST_SETUP;
                        bits_left <= BW'(1);
                        full_q    <= 1'b0;
                        dir_q     <= dir_rx_i;
                        ce_q      <= 1'b0;
                    end
                end
                ST_SETUP: begin
                    if (tmr_zero) st <= ST_LOW;
                end
                ST_LOW: begin
                    if (tmr_zero) st <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (tmr_zero) begin
                        if (last_bit) begin
                            st   <= ST_IDLE;
                            ce_q <= !full_q && dir_q;
                        end else begin
                            st        <= ST_LOW;
                            bits_left <= bits_left - 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Pin decode from the phase
    always_comb begin
        cs_o      = (st == ST_SETUP) || (st == ST_LOW) || (st == ST_HIGH);
        sclk_o    = (st == ST_HIGH);
        data_o    = cs_o && sh_msb;
        data_oe_o = cs_o || (st == ST_PWRUP);
        busy_o    = (st != ST_IDLE);
        ce_o      = ce_q;
        cfg_err_o = err_q;
    end

endmodule

// File: rtl/tw_cfg_ctrl_chk.sv
// Module tw_cfg_ctrl_chk
// Port-level protocol checks for tw_cfg_ctrl, attached with bind.
// Assumes: synchronous active-low reset on rst_n.
module tw_cfg_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_o,
    input logic cs_o,
    input logic sclk_o,
    input logic data_o,
    input logic data_oe_o,
    input logic busy_o,
    input logic cfg_err_o
);

    AST_CLK_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> cs_o); // R4
    AST_DATA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(data_o)); // R4
    AST_CLK_RISE_NO_DATA_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(data_o)); // R4
    AST_DRIVE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_o |-> data_oe_o); // R6
    AST_CE_LOW_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_o |-> !ce_o); // R5
    AST_CS_DROP_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_o) |-> !sclk_o); // R6
    AST_BUSY_COVERS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_o |-> busy_o); // R8
    AST_ERR_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err_o) |-> !cs_o); // R7

endmodule

bind tw_cfg_ctrl tw_cfg_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_o      (ce_o),
    .cs_o      (cs_o),
    .sclk_o    (sclk_o),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .busy_o    (busy_o),
    .cfg_err_o (cfg_err_o)
);

// File: tb/tw_cfg_ctrl_tb_top.sv
// Bench for tw_cfg_ctrl: a queue of expected pin states per cycle is filled
// from the requirements when a command is issued and compared on every
// falling clock edge; an empty queue means the idle pin state.
module tw_cfg_ctrl_tb_top;

    localparam int PWR  = 20;
    localparam int SET  = 4;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_full_i = 1'b0;
    logic        start_dir_i = 1'b0;
    logic        dir_rx_i = 1'b0;
    logic [7:0]  pay2_w_i = '0;
    logic [7:0]  pay1_w_i = '0;
    logic [39:0] addr2_i = '0;
    logic [39:0] addr1_i = '0;
    logic [5:0]  addr_w_i = '0;
    logic        crc16_i = 1'b0;
    logic        crc_en_i = 1'b0;
    logic        dual_rx_i = 1'b0;
    logic        burst_i = 1'b0;
    logic        rate_1m_i = 1'b0;
    logic [2:0]  xtal_i = '0;
    logic [1:0]  power_i = '0;
    logic [6:0]  rf_chan_i = '0;
    logic        rx_en_i = 1'b0;
    logic        ce_o, cs_o, sclk_o, data_o, data_oe_o, busy_o, cfg_err_o;

    int tests = 0;
    int fails = 0;
    logic [5:0] expq [$];
    logic       bitq [$];
    logic       exp_ce = 1'b0;
    logic       exp_err = 1'b0;
    logic       chk_on = 1'b0;
    string      data_req = "R1";

    always #5 clk = ~clk;

    tw_cfg_ctrl #(
        .PWRUP_CYC (PWR),
        .SETUP_CYC (SET),
        .HALF_CYC  (HALF)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_full_i(start_full_i),
        .start_dir_i(start_dir_i), .dir_rx_i(dir_rx_i),
        .pay2_w_i(pay2_w_i), .pay1_w_i(pay1_w_i), .addr2_i(addr2_i),
        .addr1_i(addr1_i), .addr_w_i(addr_w_i), .crc16_i(crc16_i),
        .crc_en_i(crc_en_i), .dual_rx_i(dual_rx_i), .burst_i(burst_i),
        .rate_1m_i(rate_1m_i), .xtal_i(xtal_i), .power_i(power_i),
        .rf_chan_i(rf_chan_i), .rx_en_i(rx_en_i), .ce_o(ce_o), .cs_o(cs_o),
        .sclk_o(sclk_o), .data_o(data_o), .data_oe_o(data_oe_o),
        .busy_o(busy_o), .cfg_err_o(cfg_err_o)
    );

    // entry layout: {busy, ce, oe, data, clk, cs}
    function automatic logic [5:0] ent(logic cs, logic ck, logic d,
                                       logic oe, logic ce, logic bz);
        return {bz, ce, oe, d, ck, cs};
    endfunction

    task automatic check1(string req, string what, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t",
                     req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_on) begin
            logic [5:0] e;
            e = (expq.size() != 0) ? expq.pop_front()
                                   : ent(1'b0, 1'b0, 1'b0, 1'b0, exp_ce, 1'b0);
            check1("R4", "cs_o",      cs_o,      e[0]);
            check1("R4", "sclk_o",    sclk_o,    e[1]);
            check1(data_req, "data_o", data_o,   e[2]);
            check1("R6", "data_oe_o", data_oe_o, e[3]);
            check1("R6", "ce_o",      ce_o,      e[4]);
            check1("R8", "busy_o",    busy_o,    e[5]);
            check1("R7", "cfg_err_o", cfg_err_o, exp_err);
        end
    end

    // turn bitq into expected cycles: setup, then low/high per bit
    task automatic push_frame();
        for (int s = 0; s < SET; s++) expq.push_back(ent(1, 0, bitq[0], 1, 0, 1));
        foreach (bitq[i]) begin
            for (int h = 0; h < HALF; h++) expq.push_back(ent(1, 0, bitq[i], 1, 0, 1));
            for (int h = 0; h < HALF; h++) expq.push_back(ent(1, 1, bitq[i], 1, 0, 1));
        end
    endtask

    function automatic logic model_err();
        int c, t1, t2;
        c  = crc_en_i ? (crc16_i ? 16 : 8) : 0;
        t1 = int'(pay1_w_i) + int'(addr_w_i) + c;
        t2 = int'(pay2_w_i) + int'(addr_w_i) + c;
        return (t1 > 256) || (t2 > 256) || (addr_w_i > 6'd40);
    endfunction

    // frame bytes in send order, MSB first within each byte (R2, R3)
    task automatic build_full_bits();
        logic [7:0] by [15];
        by[0] = pay2_w_i;
        by[1] = pay1_w_i;
        for (int k = 0; k < 5; k++) begin
            by[2 + k] = addr2_i[8*(4-k) +: 8];
            by[7 + k] = addr1_i[8*(4-k) +: 8];
        end
        by[12] = {addr_w_i, crc16_i, crc_en_i};
        by[13] = {dual_rx_i, burst_i, rate_1m_i, xtal_i, power_i};
        by[14] = {rf_chan_i, rx_en_i};
        bitq.delete();
        for (int b = 0; b < 15; b++)
            for (int j = 7; j >= 0; j--) bitq.push_back(by[b][j]);
    endtask

    task automatic settle();
        while (expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic kick_full(logic also_dir);
        logic er;
        er = model_err();
        @(negedge clk); #1;
        data_req = also_dir ? "R9" : "R2/R3";
        if (!er) begin
            build_full_bits();
            push_frame();
        end
        start_full_i = 1'b1;
        start_dir_i  = also_dir;
        @(posedge clk); #1;
        start_full_i = 1'b0;
        start_dir_i  = 1'b0;
        exp_err = er;
        if (!er) exp_ce = 1'b0;
    endtask

    task automatic kick_dir(logic rx);
        @(negedge clk); #1;
        data_req = "R5";
        bitq.delete();
        bitq.push_back(rx);
        push_frame();
        start_dir_i = 1'b1;
        dir_rx_i    = rx;
        @(posedge clk); #1;
        start_dir_i = 1'b0;
        exp_ce = rx;
    endtask

    task automatic pulse_ignored();
        @(negedge clk); #1;
        start_full_i = 1'b1;
        start_dir_i  = 1'b1;
        @(posedge clk); #1;
        start_full_i = 1'b0;
        start_dir_i  = 1'b0;
    endtask

    task automatic set_a();
        pay2_w_i = 8'd16; pay1_w_i = 8'd16;
        addr2_i = 40'h00_0000_4242; addr1_i = 40'h12_3456_789A;
        addr_w_i = 6'd16; crc16_i = 1; crc_en_i = 1;
        dual_rx_i = 0; burst_i = 1; rate_1m_i = 1; xtal_i = 3'b011;
        power_i = 2'b11; rf_chan_i = 7'd64; rx_en_i = 1;
    endtask

    // watchdog
    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check1("R1", "reset cs_o", cs_o, 1'b0);
        check1("R1", "reset busy_o", busy_o, 1'b1);
        check1("R1", "reset data_oe_o", data_oe_o, 1'b1);
        check1("R1", "reset ce_o", ce_o, 1'b0);
        // R1: power-up hold, expected PWR-1 compared cycles after release
        for (int i = 0; i < PWR - 1; i++) expq.push_back(ent(0, 0, 0, 1, 0, 1));
        #1;
        rst_n  = 1'b1;
        chk_on = 1'b1;
        repeat (5) @(negedge clk);
        pulse_ignored();  // R1: commands during power-up ignored
        settle();

        set_a();
        kick_full(1'b0);  // R2, R3, R4, R6: full load, receive bit set
        repeat (60) @(negedge clk);
        pulse_ignored();  // R8: commands mid-frame ignored
        settle();

        kick_dir(1'b1);   // R5, R6: switch to receive, ce high after
        settle();
        kick_dir(1'b0);   // R5: switch to transmit
        settle();

        // R7: exact 256 with 16-bit CRC accepted, other field values (R3)
        pay2_w_i = 8'd200; pay1_w_i = 8'd224; addr_w_i = 6'd16;
        addr2_i = 40'hA5_5A_C3_3C_F0; addr1_i = 40'h0F_1E_2D_3C_4B;
        dual_rx_i = 1; burst_i = 0; rate_1m_i = 0; xtal_i = 3'b100;
        power_i = 2'b01; rf_chan_i = 7'h55; rx_en_i = 0;
        kick_full(1'b0);
        settle();

        pay2_w_i = 8'd241;  // R7: 273 rejected
        kick_full(1'b0);
        settle();
        kick_dir(1'b1);     // R7: error flag survives a direction command
        settle();

        pay2_w_i = 8'd8; pay1_w_i = 8'd8; addr_w_i = 6'd41;  // R7: width 41
        kick_full(1'b0);
        settle();

        crc_en_i = 0; addr_w_i = 6'd1; pay1_w_i = 8'd255; pay2_w_i = 8'd255;
        kick_full(1'b0);    // R7: 256 with CRC off accepted, flag cleared
        settle();
        addr_w_i = 6'd2;    // R7: 257 with CRC off rejected
        kick_full(1'b0);
        settle();

        set_a();
        kick_dir(1'b1);
        settle();
        kick_full(1'b1);    // R9: simultaneous commands, full load wins
        settle();

        chk_on = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule